// File: doc/BRIEF.md
# Cascaded Rotating-Priority Interrupt Arbiter

This block resolves priority and handles acknowledge for two 8-line interrupt controllers. The secondary controller feeds line 2 of the primary. Each controller keeps its own request register, in-service register and rotation offset. The block takes already-captured request pulses, per-line masks, vector bases and mode flags. From these it drives a level interrupt output toward the CPU. On an acknowledge command it returns an 8-bit vector.

The CPU side issues one command per cycle on a small command port. The commands are acknowledge, end-of-interrupt (EOI) in its several forms, priority setting and poll. Acknowledge and poll return a response one cycle later.

In priority search, the line at the controller's offset ranks first. Ranks then rise with line number, wrapping modulo 8. A request interrupts only when it outranks everything in service. In special fully nested mode, the primary leaves its cascade line out of that comparison, so a secondary line of higher rank can nest under a secondary line that is already in service.

Top module: `icp_cascade_arb`

## Requirements
- R1: For each controller, the rank of line L is (L - offset) mod 8. Rank 0 is highest. Reset leaves the offset at 0, so line 0 ranks first. `offs_o[2:0]` shows the primary offset and `offs_o[5:3]` shows the secondary offset.
- R2: A controller has an interrupt only when its best unmasked request outranks its best in-service line. An empty in-service register counts as rank 8. `mask_i` bit k masks line k, where bits 7:0 belong to the primary and bits 15:8 to the secondary. `int_o` is the primary's interrupt condition, evaluated combinationally.
- R3: When `sfnm_i` is 1, the primary ignores its in-service bit 2 in the R2 comparison.
- R4: Whenever the secondary has an interrupt, primary request bit 2 is set at the next clock edge.
- R5: `cmd_op_i` 0 is acknowledge, and it ignores `cmd_sel_i`. With `int_o` high, it clears the winning primary line's request bit and sets its in-service bit. It returns `base_p_i` + line. If the winning line is 2, it does the same on the secondary and returns `base_s_i` + secondary line. If the secondary has no interrupt, it returns `base_s_i` + 7.
- R6: An acknowledge while `int_o` is low returns `base_p_i` + 7 and leaves the in-service registers and offsets unchanged.
- R7: With `aeoi_i[c]` = 1, acknowledge leaves controller c's in-service bit clear. If `rot_aeoi_i[c]` = 1 as well, that controller's offset becomes (line + 1) mod 8. In `aeoi_i`, `rot_aeoi_i`, `cmd_sel_i` and the offsets, index 0 is the primary and index 1 is the secondary.
- R8: Op 1 (non-specific EOI) clears the highest-ranked in-service bit of controller `cmd_sel_i`. Op 2 does the same and also sets the offset to (line + 1) mod 8. Neither op has any effect when nothing is in service.
- R9: Op 3 clears in-service bit `cmd_line_i`. Op 4 does the same and also sets the offset to `cmd_line_i` + 1. Op 5 only sets the offset to `cmd_line_i` + 1. Op 7 does nothing.
- R10: Op 6 (poll) returns the winning line number and clears both its request bit and its in-service bit. It sets nothing. A poll of the secondary also clears primary request bit 2 and primary in-service bit 2. With no interrupt, a poll returns 7.
- R11: `rsp_valid_o` is high exactly in the cycle after an acknowledge or a poll command, and `rsp_data_o` holds the response. A `req_i` pulse sets its request bit at the next edge, even when a command clears the same bit in that cycle.
- R12: Reset clears the request registers, the in-service registers, the offsets and `rsp_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Captured request pulses, secondary on 15:8 |
| mask_i | input | 16 | Per-line mask, secondary on 15:8 |
| base_p_i | input | 8 | Primary vector base |
| base_s_i | input | 8 | Secondary vector base |
| sfnm_i | input | 1 | Special fully nested mode on the primary |
| aeoi_i | input | 2 | Auto-EOI per controller |
| rot_aeoi_i | input | 2 | Rotate on auto-EOI per controller |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_sel_i | input | 1 | Target controller, 1 = secondary |
| cmd_line_i | input | 3 | Line operand of specific commands |
| int_o | output | 1 | Interrupt pending to the CPU |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 8 | Vector or poll result |
| irr_o | output | 16 | Request registers |
| isr_o | output | 16 | In-service registers |
| offs_o | output | 6 | Rotation offsets |

## Verification
Two functions can touch the same request bit in one cycle.

The first case is a fresh request pulse that lands in the cycle an acknowledge or poll clears that line's request. The bench provokes it directly, pulsing line 4 during its own acknowledge. The random phase pulses sparse requests under random commands, so this collision recurs many times.

The second case is a poll of the secondary, which clears primary bit 2 in the same cycle that the cascade relay would set it. The bench forces this with a pending secondary request, and the result is judged on `irr_o`.

The bench keeps a bench-side model built from the requirements. It compares `irr_o`, `isr_o`, the offsets and the response after every edge. It compares `int_o` before each edge.

// File: rtl/icp_pkg.sv
`timescale 1ns/1ps
package icp_pkg;
  typedef enum logic [2:0] {
    OP_ACK    = 3'd0,
    OP_NSEOI  = 3'd1,
    OP_RNSEOI = 3'd2,
    OP_SEOI   = 3'd3,
    OP_RSEOI  = 3'd4,
    OP_SETPRI = 3'd5,
    OP_POLL   = 3'd6,
    OP_NOP    = 3'd7
  } icp_op_e;
endpackage

// File: rtl/icp_rot_find.sv
`timescale 1ns/1ps
// Rotating find-first: rank of first set bit counting up from off_i, N_LINES if none
module icp_rot_find #(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [LW-1:0]      off_i,
  output logic [LW:0]        rank_o
);
  logic [LW-1:0] idx;
  always_comb begin
    rank_o = (LW+1)'(N_LINES);
    idx    = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      idx = off_i + LW'(i);
      if (vec_i[idx]) rank_o = (LW+1)'(i);
    end
  end
endmodule

// File: rtl/icp_ctl_eval.sv
`timescale 1ns/1ps
module icp_ctl_eval #(
  parameter int N_LINES   = 8,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic [LW-1:0]      off_i,
  input  logic               excl_casc_i,
  output logic               has_int_o,
  output logic [LW-1:0]      pend_line_o,
  output logic               isr_any_o,
  output logic [LW-1:0]      isr_line_o
);
  logic [N_LINES-1:0] pend, isr_cmp;
  logic [LW:0] pend_rank, cmp_rank, all_rank;

  assign pend = irr_i & ~mask_i;
  always_comb begin
    isr_cmp = isr_i;
    if (excl_casc_i) isr_cmp[CASC_LINE] = 1'b0;
  end

  icp_rot_find #(.N_LINES(N_LINES)) u_pend (.vec_i(pend),    .off_i(off_i), .rank_o(pend_rank));
  icp_rot_find #(.N_LINES(N_LINES)) u_cmp  (.vec_i(isr_cmp), .off_i(off_i), .rank_o(cmp_rank));
  icp_rot_find #(.N_LINES(N_LINES)) u_all  (.vec_i(isr_i),   .off_i(off_i), .rank_o(all_rank));

  // empty pend gives rank N_LINES, never below cmp_rank
  assign has_int_o   = pend_rank < cmp_rank;
  assign pend_line_o = pend_rank[LW-1:0] + off_i;
  assign isr_any_o   = ~all_rank[LW];
  assign isr_line_o  = all_rank[LW-1:0] + off_i;
endmodule

// File: rtl/icp_ctl_regs.sv
`timescale 1ns/1ps
module icp_ctl_regs #(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] irr_set_i,
  input  logic [N_LINES-1:0] irr_clr_i,
  input  logic [N_LINES-1:0] isr_set_i,
  input  logic [N_LINES-1:0] isr_clr_i,
  input  logic               off_we_i,
  input  logic [LW-1:0]      off_d_i,
  output logic [N_LINES-1:0] irr_o,
  output logic [N_LINES-1:0] isr_o,
  output logic [LW-1:0]      off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_o <= '0;
      isr_o <= '0;
      off_o <= '0;
    end else begin
      // external pulses win over clears
      irr_o <= ((irr_o | irr_set_i) & ~irr_clr_i) | req_i;
      isr_o <= (isr_o & ~isr_clr_i) | isr_set_i;
      if (off_we_i) off_o <= off_d_i;
    end
  end
endmodule

// File: rtl/icp_cascade_arb.sv
`timescale 1ns/1ps
module icp_cascade_arb
  import icp_pkg::*;
#(
  parameter int N_LINES   = 8,
  parameter int CASC_LINE = 2,
  parameter int VEC_W     = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*N_LINES-1:0] req_i,
  input  logic [2*N_LINES-1:0] mask_i,
  input  logic [VEC_W-1:0]     base_p_i,
  input  logic [VEC_W-1:0]     base_s_i,
  input  logic                 sfnm_i,
  input  logic [1:0]           aeoi_i,
  input  logic [1:0]           rot_aeoi_i,
  input  logic                 cmd_valid_i,
  input  logic [2:0]           cmd_op_i,
  input  logic                 cmd_sel_i,
  input  logic [LW-1:0]        cmd_line_i,
  output logic                 int_o,
  output logic                 rsp_valid_o,
  output logic [VEC_W-1:0]     rsp_data_o,
  output logic [2*N_LINES-1:0] irr_o,
  output logic [2*N_LINES-1:0] isr_o,
  output logic [2*LW-1:0]      offs_o
);
  localparam int NC  = 2;
  localparam int PRI = 0;
  localparam int SEC = 1;

  logic [NC-1:0][N_LINES-1:0] irr_q, isr_q, irr_set, irr_clr, isr_set, isr_clr;
  logic [NC-1:0][LW-1:0]      off_q, off_d, pend_line, isr_line;
  logic [NC-1:0]              off_we, has_int, isr_any;
  logic [VEC_W-1:0]           rsp_d;
  logic                       rsp_en;
  icp_op_e                    op;

  assign op = icp_op_e'(cmd_op_i);

  for (genvar c = 0; c < NC; c++) begin : g_ctl
    icp_ctl_regs #(.N_LINES(N_LINES)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req_i[c*N_LINES +: N_LINES]),
      .irr_set_i(irr_set[c]),
      .irr_clr_i(irr_clr[c]),
      .isr_set_i(isr_set[c]),
      .isr_clr_i(isr_clr[c]),
      .off_we_i (off_we[c]),
      .off_d_i  (off_d[c]),
      .irr_o    (irr_q[c]),
      .isr_o    (isr_q[c]),
      .off_o    (off_q[c])
    );
    icp_ctl_eval #(.N_LINES(N_LINES), .CASC_LINE(CASC_LINE)) u_eval (
      .irr_i      (irr_q[c]),
      .mask_i     (mask_i[c*N_LINES +: N_LINES]),
      .isr_i      (isr_q[c]),
      .off_i      (off_q[c]),
      .excl_casc_i((c == PRI) ? sfnm_i : 1'b0),
      .has_int_o  (has_int[c]),
      .pend_line_o(pend_line[c]),
      .isr_any_o  (isr_any[c]),
      .isr_line_o (isr_line[c])
    );
  end

  always_comb begin
    irr_set = '0;
    irr_clr = '0;
    isr_set = '0;
    isr_clr = '0;
    off_we  = '0;
    off_d   = '0;
    rsp_d   = '0;
    rsp_en  = 1'b0;
    // cascade relay: secondary interrupt raises primary request on the cascade line
    irr_set[PRI][CASC_LINE] = has_int[SEC];
    if (cmd_valid_i) begin
      unique case (op)
        OP_ACK: begin
          rsp_en = 1'b1;
          if (has_int[PRI]) begin
            irr_clr[PRI][pend_line[PRI]] = 1'b1;
            if (!aeoi_i[PRI]) isr_set[PRI][pend_line[PRI]] = 1'b1;
            else if (rot_aeoi_i[PRI]) begin
              off_we[PRI] = 1'b1;
              off_d[PRI]  = pend_line[PRI] + 1'b1;
            end
            if (pend_line[PRI] == LW'(CASC_LINE)) begin
              if (has_int[SEC]) begin
                irr_clr[SEC][pend_line[SEC]] = 1'b1;
                if (!aeoi_i[SEC]) isr_set[SEC][pend_line[SEC]] = 1'b1;
                else if (rot_aeoi_i[SEC]) begin
                  off_we[SEC] = 1'b1;
                  off_d[SEC]  = pend_line[SEC] + 1'b1;
                end
                rsp_d = base_s_i + VEC_W'(pend_line[SEC]);
              end else begin
                rsp_d = base_s_i + VEC_W'(N_LINES - 1);
              end
            end else begin
              rsp_d = base_p_i + VEC_W'(pend_line[PRI]);
            end
          end else begin
            rsp_d = base_p_i + VEC_W'(N_LINES - 1);
          end
        end
        OP_NSEOI, OP_RNSEOI: begin
          if (isr_any[cmd_sel_i]) begin
            isr_clr[cmd_sel_i][isr_line[cmd_sel_i]] = 1'b1;
            if (op == OP_RNSEOI) begin
              off_we[cmd_sel_i] = 1'b1;
              off_d[cmd_sel_i]  = isr_line[cmd_sel_i] + 1'b1;
            end
          end
        end
        OP_SEOI: isr_clr[cmd_sel_i][cmd_line_i] = 1'b1;
        OP_RSEOI: begin
          isr_clr[cmd_sel_i][cmd_line_i] = 1'b1;
          off_we[cmd_sel_i] = 1'b1;
          off_d[cmd_sel_i]  = cmd_line_i + 1'b1;
        end
        OP_SETPRI: begin
          off_we[cmd_sel_i] = 1'b1;
          off_d[cmd_sel_i]  = cmd_line_i + 1'b1;
        end
        OP_POLL: begin
          rsp_en = 1'b1;
          if (has_int[cmd_sel_i]) begin
            irr_clr[cmd_sel_i][pend_line[cmd_sel_i]] = 1'b1;
            isr_clr[cmd_sel_i][pend_line[cmd_sel_i]] = 1'b1;
            if (cmd_sel_i) begin
              irr_clr[PRI][CASC_LINE] = 1'b1;
              isr_clr[PRI][CASC_LINE] = 1'b1;
            end
            rsp_d = VEC_W'(pend_line[cmd_sel_i]);
          end else begin
            rsp_d = VEC_W'(N_LINES - 1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rsp_en;
      if (rsp_en) rsp_data_o <= rsp_d;
    end
  end

  assign int_o  = has_int[PRI];
  assign irr_o  = irr_q;
  assign isr_o  = isr_q;
  assign offs_o = off_q;
endmodule

// File: rtl/icp_cascade_arb_chk.sv
`timescale 1ns/1ps
module icp_cascade_arb_chk
  import icp_pkg::*;
#(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2*N_LINES-1:0] req_i,
  input logic [2*N_LINES-1:0] mask_i,
  input logic                 cmd_valid_i,
  input logic [2:0]           cmd_op_i,
  input logic                 cmd_sel_i,
  input logic [LW-1:0]        cmd_line_i,
  input logic                 int_o,
  input logic                 rsp_valid_o,
  input logic [2*N_LINES-1:0] irr_o,
  input logic [2*N_LINES-1:0] isr_o,
  input logic [2*LW-1:0]      offs_o
);
  logic          rsp_cmd, is_seoi, is_setpri;
  logic [LW:0]   bit_idx;
  logic [LW-1:0] line_inc;

  assign rsp_cmd   = cmd_valid_i && (cmd_op_i == OP_ACK || cmd_op_i == OP_POLL);
  assign is_seoi   = cmd_valid_i && (cmd_op_i == OP_SEOI || cmd_op_i == OP_RSEOI);
  assign is_setpri = cmd_valid_i && (cmd_op_i == OP_SETPRI);
  assign bit_idx   = {cmd_sel_i, cmd_line_i};
  assign line_inc  = cmd_line_i + 1'b1;

  // R11
  rsp_follows_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_cmd |=> rsp_valid_o);
  // R11
  no_rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_cmd |=> !rsp_valid_o);
  // R11
  req_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((irr_o & $past(req_i)) == $past(req_i)));
  // R6
  spurious_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_ACK && !int_o) |=> ($stable(isr_o) && $stable(offs_o)));
  // R9
  seoi_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_seoi |=> !isr_o[$past(bit_idx)]);
  // R9
  setpri_pri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_setpri && !cmd_sel_i) |=> offs_o[LW-1:0] == $past(line_inc));
  // R9
  setpri_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_setpri && cmd_sel_i) |=> offs_o[2*LW-1:LW] == $past(line_inc));
  // R2
  int_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr_o[N_LINES-1:0] & ~mask_i[N_LINES-1:0]));
endmodule

bind icp_cascade_arb icp_cascade_arb_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .mask_i     (mask_i),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .cmd_sel_i  (cmd_sel_i),
  .cmd_line_i (cmd_line_i),
  .int_o      (int_o),
  .rsp_valid_o(rsp_valid_o),
  .irr_o      (irr_o),
  .isr_o      (isr_o),
  .offs_o     (offs_o)
);

// File: tb/icp_cascade_arb_tb_top.sv
`timescale 1ns/1ps
module icp_cascade_arb_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0, mask_i = '0;
  logic [7:0]  base_p_i = 8'h08, base_s_i = 8'h70;
  logic        sfnm_i = 1'b0;
  logic [1:0]  aeoi_i = '0, rot_aeoi_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_op_i = 3'd7;
  logic        cmd_sel_i = 1'b0;
  logic [2:0]  cmd_line_i = '0;
  logic        int_o, rsp_valid_o;
  logic [7:0]  rsp_data_o;
  logic [15:0] irr_o, isr_o;
  logic [5:0]  offs_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  icp_cascade_arb dut_i (.*);

  // bench model state
  logic [7:0] m_irr [2], m_isr [2];
  logic [2:0] m_off [2];
  logic       m_rv;
  logic [7:0] m_rd;
  logic [7:0] n_irr [2], n_isr [2];
  logic [2:0] n_off [2];
  logic       n_rv;
  logic [7:0] n_rd;

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  function automatic int rnk(logic [7:0] v, logic [2:0] o);
    for (int i = 0; i < 8; i++) if (v[3'(o + 3'(i))]) return i;
    return 8;
  endfunction

  function automatic logic [7:0] pend_of(int c);
    return m_irr[c] & ~mask_i[c*8 +: 8];
  endfunction

  function automatic bit m_has(int c);
    logic [7:0] ic = m_isr[c];
    int pr;
    if (c == 0 && sfnm_i) ic[2] = 1'b0;
    pr = rnk(pend_of(c), m_off[c]);
    return pr < 8 && pr < rnk(ic, m_off[c]);
  endfunction

  function automatic logic [2:0] m_pline(int c);
    return 3'(rnk(pend_of(c), m_off[c]) + int'(m_off[c]));
  endfunction

  task automatic model_next(input logic [15:0] req, input logic v, input logic [2:0] op,
                            input logic sel, input logic [2:0] line);
    logic [7:0] cs [2], ic [2], ss [2], sc [2];
    bit hp, hs;
    logic [2:0] lp, ls, li;
    int c;
    c = int'(sel);
    hp = m_has(0); hs = m_has(1); lp = m_pline(0); ls = m_pline(1);
    for (int k = 0; k < 2; k++) begin
      cs[k] = '0; ic[k] = '0; ss[k] = '0; sc[k] = '0; n_off[k] = m_off[k];
    end
    cs[0][2] = hs;
    n_rv = v && (op == 3'd0 || op == 3'd6);
    n_rd = m_rd;
    if (v) begin
      case (op)
        3'd0: begin
          if (!hp) n_rd = base_p_i + 8'd7;
          else begin
            ic[0][lp] = 1'b1;
            if (!aeoi_i[0]) ss[0][lp] = 1'b1; else if (rot_aeoi_i[0]) n_off[0] = lp + 3'd1;
            if (lp != 3'd2) n_rd = base_p_i + 8'(lp);
            else if (!hs) n_rd = base_s_i + 8'd7;
            else begin
              ic[1][ls] = 1'b1;
              if (!aeoi_i[1]) ss[1][ls] = 1'b1; else if (rot_aeoi_i[1]) n_off[1] = ls + 3'd1;
              n_rd = base_s_i + 8'(ls);
            end
          end
        end
        3'd1, 3'd2: begin
          if (m_isr[c] != 0) begin
            li = 3'(rnk(m_isr[c], m_off[c]) + int'(m_off[c]));
            sc[c][li] = 1'b1;
            if (op == 3'd2) n_off[c] = li + 3'd1;
          end
        end
        3'd3: sc[c][line] = 1'b1;
        3'd4: begin sc[c][line] = 1'b1; n_off[c] = line + 3'd1; end
        3'd5: n_off[c] = line + 3'd1;
        3'd6: begin
          if (m_has(c)) begin
            li = m_pline(c);
            ic[c][li] = 1'b1; sc[c][li] = 1'b1;
            if (c == 1) begin ic[0][2] = 1'b1; sc[0][2] = 1'b1; end
            n_rd = 8'(li);
          end else n_rd = 8'd7;
        end
        default: ;
      endcase
    end
    for (int k = 0; k < 2; k++) begin
      n_irr[k] = ((m_irr[k] | cs[k]) & ~ic[k]) | req[k*8 +: 8];
      n_isr[k] = (m_isr[k] & ~sc[k]) | ss[k];
    end
  endtask

  function automatic string lbl(logic v, logic [2:0] op, bit hp);
    if (!v) return "R4";
    case (op)
      3'd0: return hp ? ((aeoi_i != 0) ? "R7" : "R5") : "R6";
      3'd1, 3'd2: return "R8";
      3'd3, 3'd4, 3'd5: return "R9";
      3'd6: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic [15:0] req, input logic v, input logic [2:0] op,
                      input logic sel, input logic [2:0] line);
    string l;
    req_i = req; cmd_valid_i = v; cmd_op_i = op; cmd_sel_i = sel; cmd_line_i = line;
    #1;
    check("R2", int_o, m_has(0));
    l = lbl(v, op, m_has(0));
    model_next(req, v, op, sel, line);
    @(posedge clk_i);
    for (int k = 0; k < 2; k++) begin
      m_irr[k] = n_irr[k]; m_isr[k] = n_isr[k]; m_off[k] = n_off[k];
    end
    m_rv = n_rv; m_rd = n_rd;
    @(negedge clk_i);
    check("R11", irr_o, {m_irr[1], m_irr[0]});
    check(l, isr_o, {m_isr[1], m_isr[0]});
    check("R1", offs_o, {m_off[1], m_off[0]});
    check("R11", rsp_valid_o, m_rv);
    if (m_rv) check(l, rsp_data_o, m_rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 3'd7, 1'b0, 3'd0);
  endtask

  task automatic do_reset();
    req_i = '0; cmd_valid_i = 1'b0; mask_i = '0; sfnm_i = 1'b0; aeoi_i = '0; rot_aeoi_i = '0;
    rst_ni = 1'b0;
    for (int k = 0; k < 2; k++) begin m_irr[k] = '0; m_isr[k] = '0; m_off[k] = '0; end
    m_rv = 1'b0; m_rd = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk_i);
    check("R12", {irr_o, isr_o}, 32'h0);
    check("R12", offs_o, 6'h0);
    check("R12", {int_o, rsp_valid_o}, 2'b00);

    // nested cascade example, R3
    sfnm_i = 1'b1;
    step(16'h1000, 0, 3'd7, 0, 0); idle(2);
    step('0, 1, 3'd0, 0, 0);
    check("R5", rsp_data_o, 8'h74);
    sfnm_i = 1'b0;
    step(16'h0100, 0, 3'd7, 0, 0); idle(2);
    check("R3", int_o, 1'b0);
    sfnm_i = 1'b1; #1;
    check("R3", int_o, 1'b1);
    step('0, 1, 3'd0, 0, 0);
    check("R3", rsp_data_o, 8'h70);
    check("R3", isr_o, 16'h1104);

    // rotation, R1
    do_reset(); @(negedge clk_i);
    step('0, 1, 3'd5, 0, 3'd4);
    step(16'h0048, 0, 3'd7, 0, 0); idle(1);
    step('0, 1, 3'd0, 0, 0);
    check("R1", rsp_data_o, 8'h0E);

    // auto-EOI with rotation, R7
    do_reset(); @(negedge clk_i);
    aeoi_i = 2'b11; rot_aeoi_i = 2'b01;
    step(16'h0020, 0, 3'd7, 0, 0); idle(1);
    step('0, 1, 3'd0, 0, 0);
    check("R7", rsp_data_o, 8'h0D);
    check("R7", isr_o, 16'h0);
    check("R7", offs_o[2:0], 3'd6);

    // spurious cascade and idle acknowledge, R5 R6
    do_reset(); @(negedge clk_i);
    step(16'h0004, 0, 3'd7, 0, 0); idle(1);
    step('0, 1, 3'd0, 0, 0);
    check("R5", rsp_data_o, 8'h77);
    step('0, 1, 3'd0, 0, 0);
    check("R6", rsp_data_o, 8'h0F);

    // poll of secondary, R10
    do_reset(); @(negedge clk_i);
    step(16'h1000, 0, 3'd7, 0, 0); idle(2);
    step('0, 1, 3'd6, 1, 0);
    check("R10", rsp_data_o, 8'h04);
    check("R10", irr_o, 16'h0);
    idle(1);
    step('0, 1, 3'd6, 1, 0);
    check("R10", rsp_data_o, 8'h07);

    // request pulse in the cycle its line is acknowledged, R11
    do_reset(); @(negedge clk_i);
    step(16'h0010, 0, 3'd7, 0, 0); idle(1);
    step(16'h0010, 1, 3'd0, 0, 0);
    check("R11", irr_o[4], 1'b1);
    check("R11", isr_o[4], 1'b1);

    // random phase
    do_reset(); @(negedge clk_i);
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] rq;
      if (k % 250 == 0) begin
        mask_i = 16'($urandom) & 16'($urandom);
        sfnm_i = 1'($urandom);
        aeoi_i = 2'($urandom);
        rot_aeoi_i = 2'($urandom);
        base_p_i = 8'($urandom) & 8'hF8;
        base_s_i = 8'($urandom) & 8'hF8;
      end
      rq = 16'($urandom) & 16'($urandom) & 16'($urandom) & 16'($urandom);
      step(rq, 1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom));
    end
    req_i = '0; cmd_valid_i = 1'b0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end
endmodule